// File: doc/BRIEF.md
# Configurable multi-term multiply-accumulate unit

This block adds up a set of terms into one result that is `W` bits wide. Each term is either a product of two operands or a single operand on its own. The terms are described entirely by one packed configuration parameter. That parameter is decoded while the design is elaborated, so no configuration logic is built in hardware. All operands arrive back to back on one packed data bus. A second bus carries single-bit unsigned increments, and every bit of it is added to the sum.

The configuration string describes itself. Its lowest four bits give a size-field width `N`. After those four bits comes one record per term, laid out upward from low bits:
- a signed flag;
- a subtract flag;
- the size of operand A, `N` bits, least significant bit first;
- the size of operand B, `N` bits, least significant bit first.

Elaboration stops with a fatal message in any of these cases:
- the records do not fill the string exactly;
- the operand sizes do not add up to the data bus width;
- a term has an A size of zero.

The data crosses the block as a stream with valid/ready handshakes. With `REG_OUT=1`, a one-entry output stage holds the result. That stage accepts a new input whenever it is empty or its content is taken in the same cycle. While `out_valid` is high and `out_ready` is low, the stage holds its data and drops `in_ready`. With `REG_OUT=0`, the result is combinational, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `macc_unit`

## Requirements
- R1: The low 4 bits of `CFG` (LSB first) give the size-field width N. Term records follow from bit 4 upward, each laid out as signed flag, subtract flag, N-bit A size, N-bit B size, with sizes LSB first.
- R2: Operand slices are taken from `in_data` in term order, starting at bit 0. Each term's A slice comes first, then its B slice, with no gaps between slices.
- R3: A term whose B size is zero contributes its A operand alone, extended to W bits. Any other term contributes the product A×B.
- R4: In a signed term both operands are sign-extended and multiplied as two's complement values. In an unsigned term both operands are zero-extended.
- R5: A term with the subtract flag set is subtracted from the running sum. Every other term is added.
- R6: Each bit of `in_bits` adds 0 or 1 to the sum as an unsigned value.
- R7: The sum starts at zero and wraps modulo 2^W. When all inputs are zero, the output is zero.
- R8: With `REG_OUT=1`, the result of an accepted input (`in_valid && in_ready` at a clock edge) appears on `out_data`, with `out_valid` high, right after that edge. Synchronous reset drives `out_valid` low and `out_data` to zero.
- R9: With `REG_OUT=1`, while `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R10: With `REG_OUT=0`, `out_data` is the sum of the current inputs, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat is valid |
| in_ready | output | 1 | Block can take an operand beat |
| in_data | input | A_W | Packed operand slices, back to back from bit 0 |
| in_bits | input | BITS_W | Single-bit unsigned increments |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | W | Sum modulo 2^W |

## Verification
The registered build uses a four-term string. It is fed single-term patterns that separate the roles of the flags:
- an unsigned product;
- a signed subtracted product with both operands negative;
- a signed A-only term holding its most negative value;
- an unsigned subtracted A-only term;
- the increments alone.

A long pseudo-random run on the same build then exposes slice-offset and ordering mistakes. The run uses operands that mix terms with each other.

A second, combinational build uses a different string, with N=2, a signed 3×2 product and an unsigned subtracted term. That build is swept over every data and increment value. Toggling `out_ready` during the sweep exercises its handshake pass-through.

A stall sequence shows that a held result cannot be overwritten and that readiness returns as soon as the downstream accepts.

// File: rtl/macc_pkg.sv
package macc_pkg;

  // Largest configuration string the decoder walks.
  localparam int CFG_MAX = 512;
  // Upper bound on terms the decoder walks.
  localparam int MAX_TERMS = 64;

  // Field selectors for cfg_walk.
  localparam int SEL_SGN   = 0;
  localparam int SEL_SUB   = 1;
  localparam int SEL_SZA   = 2;
  localparam int SEL_SZB   = 3;
  localparam int SEL_OFF   = 4;
  localparam int SEL_COUNT = 5;
  localparam int SEL_CBITS = 6;
  localparam int SEL_DBITS = 7;
  localparam int SEL_BAD   = 8;

  // Read n bits LSB first starting at pos.
  function automatic int cfg_rd(input logic [CFG_MAX-1:0] c, input int pos, input int n);
    int v;
    v = 0;
    for (int i = 0; i < n; i++) begin
      if ((pos + i) < CFG_MAX && c[pos+i]) v = v | (1 << i);
    end
    return v;
  endfunction

  // Walk the records. For a term field selector, idx names the term;
  // for the summary selectors, idx is ignored.
  function automatic int cfg_walk(input logic [CFG_MAX-1:0] c, input int a_w,
                                  input int idx, input int sel);
    int n, pos, cur, cnt, bad;
    int sg, sb, za, zb;
    n   = cfg_rd(c, 0, 4);
    pos = 4;
    cur = 0;
    cnt = 0;
    bad = (n == 0) ? 1 : 0;
    for (int k = 0; k < MAX_TERMS; k++) begin
      if (cur < a_w && bad == 0) begin
        sg = cfg_rd(c, pos, 1);
        sb = cfg_rd(c, pos + 1, 1);
        za = cfg_rd(c, pos + 2, n);
        zb = cfg_rd(c, pos + 2 + n, n);
        if (k == idx) begin
          case (sel)
            SEL_SGN: return sg;
            SEL_SUB: return sb;
            SEL_SZA: return za;
            SEL_SZB: return zb;
            SEL_OFF: return cur;
            default: ;
          endcase
        end
        if (za == 0) bad = 1;
        pos = pos + 2 + 2 * n;
        cur = cur + za + zb;
        cnt = cnt + 1;
      end
    end
    if (cur < a_w) bad = 1;
    case (sel)
      SEL_COUNT: return cnt;
      SEL_CBITS: return pos;
      SEL_DBITS: return cur;
      SEL_BAD:   return bad;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/macc_term.sv
module macc_term #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int BW    = 1,
  parameter bit HAS_B = 1'b1,
  parameter bit SGN   = 1'b0,
  parameter bit SUB   = 1'b0
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [W-1:0]  acc_in,
  output logic [W-1:0]  acc_out
);

  logic [W-1:0] ext_a;
  logic [W-1:0] ext_b;
  logic [W-1:0] prod;

  // Operand extension to the result width.
  if (SGN) begin : g_sext
    assign ext_a = W'($signed(a));
    assign ext_b = W'($signed(b));
  end else begin : g_zext
    assign ext_a = W'($unsigned(a));
    assign ext_b = W'($unsigned(b));
  end

  // Product or plain operand; low W bits of a product of W-bit
  // extended values equal the true product modulo 2^W.
  if (HAS_B) begin : g_mul
    assign prod = ext_a * ext_b;
  end else begin : g_pass
    logic [W-1:0] unused_b;
    assign unused_b = ext_b;
    assign prod     = ext_a;
  end

  if (SUB) begin : g_sub
    assign acc_out = acc_in - prod;
  end else begin : g_add
    assign acc_out = acc_in + prod;
  end

endmodule

// File: rtl/macc_bitsum.sv
module macc_bitsum #(
  parameter int W      = 8,
  parameter int BITS_W = 3
) (
  input  logic [BITS_W-1:0] bits,
  output logic [W-1:0]      cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < BITS_W; i++) begin
      cnt = cnt + W'(bits[i]);
    end
  end

endmodule

// File: rtl/macc_out_stage.sv
module macc_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] sum,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (REG_OUT) begin : g_reg
    logic         hold_v;
    logic [W-1:0] hold_d;

    assign in_ready = !hold_v || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_v <= 1'b0;
        hold_d <= '0;
      end else if (in_valid && in_ready) begin
        hold_v <= 1'b1;
        hold_d <= sum;
      end else if (out_ready) begin
        hold_v <= 1'b0;
      end
    end

    assign out_valid = hold_v;
    assign out_data  = hold_d;

    AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid && out_data == $past(sum)); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid && out_data == '0); // R8
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_data   = sum;
  end

endmodule

// File: rtl/macc_unit.sv
module macc_unit #(
  parameter int W       = 8,
  parameter int A_W     = 20,
  parameter int BITS_W  = 3,
  parameter int CFG_W   = 36,
  parameter logic [CFG_W-1:0] CFG = {
    3'd0, 3'd2, 1'b1, 1'b0,   // term 3: unsigned, subtract, A=2, no B
    3'd0, 3'd4, 1'b0, 1'b1,   // term 2: signed, add, A=4, no B
    3'd3, 3'd3, 1'b1, 1'b1,   // term 1: signed, subtract, 3x3
    3'd4, 3'd4, 1'b0, 1'b0,   // term 0: unsigned, add, 4x4
    4'd3                      // size-field width
  },
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [A_W-1:0]    in_data,
  input  logic [BITS_W-1:0] in_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data
);

  import macc_pkg::*;

  localparam logic [CFG_MAX-1:0] CFG_EXT = CFG_MAX'(CFG);
  localparam int NT     = cfg_walk(CFG_EXT, A_W, 0, SEL_COUNT);
  localparam int USED_C = cfg_walk(CFG_EXT, A_W, 0, SEL_CBITS);
  localparam int USED_D = cfg_walk(CFG_EXT, A_W, 0, SEL_DBITS);
  localparam int BAD    = cfg_walk(CFG_EXT, A_W, 0, SEL_BAD);
  localparam bit CFG_OK = (CFG_W <= CFG_MAX) && (USED_C == CFG_W) &&
                          (USED_D == A_W) && (BAD == 0) && (NT >= 1);
  localparam int NT_E   = (NT >= 1) ? NT : 1;

  if (!CFG_OK) begin : g_cfg_bad
    $fatal(1, "macc_unit: configuration string does not match its records or the data width");
  end

  logic [W-1:0] acc [0:NT_E];
  logic [W-1:0] bit_cnt;
  logic [W-1:0] sum_all;

  assign acc[0] = '0;

  for (genvar t = 0; t < NT_E; t++) begin : g_term
    localparam int  SZA = cfg_walk(CFG_EXT, A_W, t, SEL_SZA);
    localparam int  SZB = cfg_walk(CFG_EXT, A_W, t, SEL_SZB);
    localparam int  OFF = cfg_walk(CFG_EXT, A_W, t, SEL_OFF);
    localparam bit  SG  = cfg_walk(CFG_EXT, A_W, t, SEL_SGN) != 0;
    localparam bit  SB  = cfg_walk(CFG_EXT, A_W, t, SEL_SUB) != 0;
    localparam int  AWE = (SZA > 0) ? SZA : 1;
    localparam int  BWE = (SZB > 0) ? SZB : 1;
    localparam int  BOF = OFF + SZA;

    logic [AWE-1:0] op_a;
    logic [BWE-1:0] op_b;

    assign op_a = in_data[OFF +: AWE];
    if (SZB > 0) begin : g_b
      assign op_b = in_data[BOF +: BWE];
    end else begin : g_nob
      assign op_b = '0;
    end

    macc_term #(
      .W(W), .AW(AWE), .BW(BWE), .HAS_B(SZB > 0), .SGN(SG), .SUB(SB)
    ) u_term (
      .a(op_a), .b(op_b), .acc_in(acc[t]), .acc_out(acc[t+1])
    );
  end

  macc_bitsum #(.W(W), .BITS_W(BITS_W)) u_bits (
    .bits(in_bits), .cnt(bit_cnt)
  );

  assign sum_all = acc[NT_E] + bit_cnt;

  macc_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .sum(sum_all),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
    in_data == '0 && in_bits == '0 |-> sum_all == '0); // R7
  AST_BITS_ONLY: assert property (@(posedge clk) disable iff (rst)
    in_data == '0 |-> sum_all == bit_cnt); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R9

endmodule

// File: tb/macc_unit_bench.sv
`timescale 1ns/1ps
module macc_unit_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // Build A: default four-term string, registered.
  logic        a_iv = 1'b0, a_or = 1'b1;
  logic        a_ir, a_ov;
  logic [19:0] a_d = '0;
  logic [2:0]  a_b = '0;
  logic [7:0]  a_q;

  macc_unit u_macc_unit (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir),
    .in_data(a_d), .in_bits(a_b), .out_valid(a_ov), .out_ready(a_or),
    .out_data(a_q)
  );

  // Build B: two-term string, N=2, combinational.
  logic       b_iv = 1'b0, b_or = 1'b0;
  logic       b_ir, b_ov;
  logic [7:0] b_d = '0;
  logic [1:0] b_b = '0;
  logic [4:0] b_q;

  macc_unit #(
    .W(5), .A_W(8), .BITS_W(2), .CFG_W(16),
    .CFG({2'd0, 2'd3, 1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 1'b1, 4'd2}),
    .REG_OUT(1'b0)
  ) u_macc_unit_b (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir),
    .in_data(b_d), .in_bits(b_b), .out_valid(b_ov), .out_ready(b_or),
    .out_data(b_q)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: loops over the terms of the chosen string.
  function automatic longint model(input int which, input longint data, input int bits);
    int nt, w, nb, off;
    int sg, sb, za, zb;
    longint acc, a, b, t;
    off = 0; acc = 0;
    if (which == 0) begin nt = 4; w = 8; nb = 3; end
    else begin nt = 2; w = 5; nb = 2; end
    for (int k = 0; k < nt; k++) begin
      if (which == 0) begin
        case (k)
          0: begin sg = 0; sb = 0; za = 4; zb = 4; end
          1: begin sg = 1; sb = 1; za = 3; zb = 3; end
          2: begin sg = 1; sb = 0; za = 4; zb = 0; end
          default: begin sg = 0; sb = 1; za = 2; zb = 0; end
        endcase
      end else begin
        if (k == 0) begin sg = 1; sb = 0; za = 3; zb = 2; end
        else begin sg = 0; sb = 1; za = 3; zb = 0; end
      end
      a = (data >> off) & ((64'sd1 << za) - 1);
      off += za;
      if (sg != 0 && a[za-1]) a = a - (64'sd1 << za);
      if (zb > 0) begin
        b = (data >> off) & ((64'sd1 << zb) - 1);
        off += zb;
        if (sg != 0 && b[zb-1]) b = b - (64'sd1 << zb);
        t = a * b;
      end else t = a;
      acc = (sb != 0) ? acc - t : acc + t;
    end
    for (int i = 0; i < nb; i++) acc += (bits >> i) & 1;
    return acc & ((64'sd1 << w) - 1);
  endfunction

  task automatic run_a(input logic [19:0] d, input logic [2:0] bt, input string tag);
    @(negedge clk);
    a_iv = 1'b1; a_d = d; a_b = bt; a_or = 1'b1;
    @(negedge clk);
    a_iv = 1'b0;
    chk(a_ov == 1'b1, {tag, " R8 valid"}, longint'(a_ov), 1);
    chk(a_q == 8'(model(0, longint'(d), int'(bt))), tag, longint'(a_q),
        model(0, longint'(d), int'(bt)));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog R8 actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    chk(a_ov == 1'b0, "R8 reset valid", longint'(a_ov), 0);
    chk(a_q == 8'd0, "R8 reset data", longint'(a_q), 0);
    rst = 1'b0;

    // Directed single-term patterns (in_data layout: t0 A[3:0] B[7:4],
    // t1 A[10:8] B[13:11], t2 A[17:14], t3 A[19:18]).
    run_a(20'h0, 3'b000, "R7 zero");
    run_a(20'h000FF, 3'b000, "R1 R2 unsigned product");
    run_a(20'h02400, 3'b000, "R4 R5 signed subtract product");
    run_a(20'h20000, 3'b000, "R3 R4 signed A only");
    run_a(20'hC0000, 3'b000, "R3 R5 R7 unsigned subtract wrap");
    run_a(20'h0, 3'b111, "R6 bits only");
    run_a(20'h0, 3'b010, "R6 one bit");
    run_a(20'hFFFFF, 3'b111, "R7 all ones");
    run_a(20'h00F00, 3'b000, "R2 slice boundary");

    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      run_a(lfsr[19:0], lfsr[31:29], "R1 R2 R3 R4 R5 R6 random");
    end

    // Stall: hold result while downstream is not ready.
    run_a(20'h00033, 3'b001, "R8 stall setup");
    a_or = 1'b0; a_iv = 1'b1; a_d = 20'h00055; a_b = 3'b000;
    @(negedge clk);
    chk(a_q == 8'(model(0, 64'h33, 1)), "R9 held data", longint'(a_q), model(0, 64'h33, 1));
    chk(a_ov == 1'b1, "R9 held valid", longint'(a_ov), 1);
    chk(a_ir == 1'b0, "R9 ready low", longint'(a_ir), 0);
    a_or = 1'b1;
    #1;
    chk(a_ir == 1'b1, "R9 ready returns", longint'(a_ir), 1);
    @(negedge clk);
    a_iv = 1'b0;
    chk(a_q == 8'(model(0, 64'h55, 0)), "R8 after stall", longint'(a_q), model(0, 64'h55, 0));

    // Build B: exhaustive sweep, combinational.
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      b_d = v[7:0]; b_b = v[9:8]; b_iv = v[0]; b_or = v[1];
      #1;
      chk(b_q == 5'(model(1, longint'(v[7:0]), int'(v[9:8]))),
          "R10 R1 R3 R4 R5 R6 R7 comb sum", longint'(b_q),
          model(1, longint'(v[7:0]), int'(v[9:8])));
      chk(b_ov == b_iv && b_ir == b_or, "R10 handshake pass",
          longint'({b_ov, b_ir}), longint'({b_iv, b_or}));
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule